// File: doc/BRIEF.md
# Dual-Latency Result Bus Arbiter

This block lets two pipelined floating-point units with different fixed latencies share one result write-back bus. The add path needs three clocks from issue to result and the multiply path needs four. Each path is a pipeline of valid bits that carries an operation tag and a data word. No arithmetic is performed, so the word leaves exactly as it entered. Because of the unequal depths, a multiply issued one cycle before an add reaches the bus in the same cycle as that add. The arbiter settles every such collision in favour of the multiplier.

When a collision happens, the adder's finished result stays in its last stage with its valid bit still set. The earlier adder stages freeze with it. The adder's issue-ready output drops so that the issue logic cannot push a new add into a pipe that is not moving. The multiplier never stalls, so multiply issue needs no handshake. The result bus shows at most one result per cycle, together with a bit that says which unit produced it.

Top module: `result_bus_arbiter`

## Requirements
- R1: An add accepted in cycle c (`add_issue_valid` and `add_issue_ready` both high) with no collision on its path appears on the bus in cycle c+3, with the same tag and data word.
- R2: A multiply presented in cycle c appears on the bus in cycle c+4 with the same tag and data word, whatever the adder is doing.
- R3: When both final stages hold a result in the same cycle, the multiply result is driven and `result_from_mul` is 1. The value 1 means multiplier and 0 means adder.
- R4: A displaced add result keeps its tag and data in the adder's final stage. It is driven in the first cycle in which no multiply result is due.
- R5: While the adder is held, `add_stall` is 1 and `add_issue_ready` is 0. An add presented in such a cycle is ignored and never reaches the bus.
- R6: While the adder is held, every earlier add stage freezes too, so each add behind the held one is delayed by exactly the number of held cycles.
- R7: `result_valid` is 1 exactly when either final stage holds a result. At most one result is driven per cycle. Every accepted operation appears on the bus exactly once.
- R8: A multiply issue is always accepted; the multiply path never stalls.
- R9: A synchronous active-low reset empties both pipelines and clears the hold. After it, `result_valid` and `add_stall` are 0 and `add_issue_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| add_issue_valid | input | 1 | Add operation presented |
| add_issue_tag | input | 4 | Operation id of the add |
| add_issue_data | input | 32 | Data word carried by the add |
| add_issue_ready | output | 1 | Adder can accept an add this cycle |
| mul_issue_valid | input | 1 | Multiply operation presented (always accepted) |
| mul_issue_tag | input | 4 | Operation id of the multiply |
| mul_issue_data | input | 32 | Data word carried by the multiply |
| result_valid | output | 1 | A result is on the bus |
| result_tag | output | 4 | Operation id of the driven result |
| result_data | output | 32 | Data word of the driven result |
| result_from_mul | output | 1 | 1 = multiplier result, 0 = adder result |
| add_stall | output | 1 | Adder held because the multiplier owns the bus |

## Verification
The bench goes after the exact collision pattern, a multiply followed one cycle later by an add. A design that let the adder win, or that dropped the held add, would show a late multiply or a missing tag. Long runs of back-to-back multiplies keep the adder held for many cycles. Adds presented during those cycles check that a leaked issue cannot overwrite the held result or appear as a duplicate. Random mixes check that a design that froze only the final adder stage would emit adds behind the held one at the wrong time. A reset applied with operations in flight checks that no stale result or stall survives.

// File: rtl/rba_pkg.sv
// Shared definitions for the result bus arbiter.
// Assumes: one add and one multiply pipeline share a single write-back bus.
package rba_pkg;
    localparam int DEF_TAG_W  = 4;
    localparam int DEF_DATA_W = 32;

    // Which unit owns the bus in a given cycle.
    typedef enum logic {
        SRC_ADD = 1'b0,
        SRC_MUL = 1'b1
    } wb_src_e;
endpackage

// File: rtl/rba_pipe.sv
// Fixed-depth pipeline of valid/tag/data stages used for one functional unit.
// Moves all stages forward one step when 'advance' is high and holds every stage
// otherwise. The caller gates in_valid with its own issue acceptance.
// Assumes DEPTH >= 1.
module rba_pipe #(
    parameter int DEPTH  = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    // Valid bits: cleared by reset, shift forward on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (advance) begin
            vld_q[0] <= in_valid;
            for (int s = 1; s < DEPTH; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    // Payload: tag and data move in step with the valid bits and need no reset.
    always_ff @(posedge clk) begin
        if (advance) begin
            tag_q[0]  <= in_tag;
            data_q[0] <= in_data;
            for (int s = 1; s < DEPTH; s++) begin
                tag_q[s]  <= tag_q[s-1];
                data_q[s] <= data_q[s-1];
            end
        end
    end

    // The last stage is the result offered to the bus.
    assign out_valid = vld_q[LAST];
    assign out_tag   = tag_q[LAST];
    assign out_data  = data_q[LAST];
endmodule

// File: rtl/rba_wb_sel.sv
// Write-back selector: gives the shared bus to the multiplier whenever it has a
// finished result, and otherwise to the adder. Raises add_hold when the adder's
// finished result has to wait.
// Assumes both inputs come straight from the final pipeline stages.
module rba_wb_sel
    import rba_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              add_valid,
    input  logic [TAG_W-1:0]  add_tag,
    input  logic [DATA_W-1:0] add_data,
    input  logic              mul_valid,
    input  logic [TAG_W-1:0]  mul_tag,
    input  logic [DATA_W-1:0] mul_data,
    output logic              bus_valid,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [DATA_W-1:0] bus_data,
    output wb_src_e           bus_src,
    output logic              add_hold
);
    // Fixed priority: the multiplier cannot stall, so it always wins.
    always_comb begin
        bus_valid = 1'b0;
        bus_tag   = '0;
        bus_data  = '0;
        bus_src   = SRC_ADD;
        if (mul_valid) begin
            bus_valid = 1'b1;
            bus_tag   = mul_tag;
            bus_data  = mul_data;
            bus_src   = SRC_MUL;
        end else if (add_valid) begin
            bus_valid = 1'b1;
            bus_tag   = add_tag;
            bus_data  = add_data;
        end
    end

    // The adder waits only when both units finish in the same cycle.
    assign add_hold = add_valid & mul_valid;
endmodule

// File: rtl/result_bus_arbiter.sv
// Shares one result bus between a 3-stage add pipeline and a 4-stage multiply
// pipeline. On a same-cycle completion the multiply result is driven. The whole
// add pipeline freezes, and add issue is refused until the bus frees up.
// Assumes the issue logic honours add_issue_ready; multiply issue has no handshake.
module result_bus_arbiter
    import rba_pkg::*;
#(
    parameter int ADD_LAT = 3,
    parameter int MUL_LAT = 4,
    parameter int TAG_W   = DEF_TAG_W,
    parameter int DATA_W  = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_issue_valid,
    input  logic [TAG_W-1:0]  add_issue_tag,
    input  logic [DATA_W-1:0] add_issue_data,
    output logic              add_issue_ready,
    input  logic              mul_issue_valid,
    input  logic [TAG_W-1:0]  mul_issue_tag,
    input  logic [DATA_W-1:0] mul_issue_data,
    output logic              result_valid,
    output logic [TAG_W-1:0]  result_tag,
    output logic [DATA_W-1:0] result_data,
    output logic              result_from_mul,
    output logic              add_stall
);
    logic              add_last_valid;
    logic [TAG_W-1:0]  add_last_tag;
    logic [DATA_W-1:0] add_last_data;
    logic              mul_last_valid;
    logic [TAG_W-1:0]  mul_last_tag;
    logic [DATA_W-1:0] mul_last_data;
    logic              add_hold;
    wb_src_e           bus_src;

    // Adder path: advances unless its finished result is being held.
    rba_pipe #(
        .DEPTH  (ADD_LAT),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_add_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!add_hold),
        .in_valid  (add_issue_valid && !add_hold),
        .in_tag    (add_issue_tag),
        .in_data   (add_issue_data),
        .out_valid (add_last_valid),
        .out_tag   (add_last_tag),
        .out_data  (add_last_data)
    );

    // Multiplier path: always advances.
    rba_pipe #(
        .DEPTH  (MUL_LAT),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_mul_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (1'b1),
        .in_valid  (mul_issue_valid),
        .in_tag    (mul_issue_tag),
        .in_data   (mul_issue_data),
        .out_valid (mul_last_valid),
        .out_tag   (mul_last_tag),
        .out_data  (mul_last_data)
    );

    // Bus ownership and the adder hold decision.
    rba_wb_sel #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_sel (
        .add_valid (add_last_valid),
        .add_tag   (add_last_tag),
        .add_data  (add_last_data),
        .mul_valid (mul_last_valid),
        .mul_tag   (mul_last_tag),
        .mul_data  (mul_last_data),
        .bus_valid (result_valid),
        .bus_tag   (result_tag),
        .bus_data  (result_data),
        .bus_src   (bus_src),
        .add_hold  (add_hold)
    );

    // Outward status toward issue and write-back.
    assign result_from_mul = (bus_src == SRC_MUL);
    assign add_stall       = add_hold;
    assign add_issue_ready = !add_hold;
endmodule

// File: rtl/rba_checker.sv
// Assertion checker for result_bus_arbiter, attached through bind.
// Watches the final pipeline stages against the bus and the issue handshake.
module rba_checker #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              add_last_valid,
    input logic [TAG_W-1:0]  add_last_tag,
    input logic [DATA_W-1:0] add_last_data,
    input logic              mul_last_valid,
    input logic              result_valid,
    input logic              result_from_mul,
    input logic              add_stall,
    input logic              add_issue_ready
);
    // R3
    mul_wins_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_last_valid |-> (result_valid && result_from_mul));

    // R4
    held_add_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_stall |=> (add_last_valid && $stable(add_last_tag) && $stable(add_last_data)));

    // R5
    stall_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_stall |-> !add_issue_ready);

    // R7
    bus_valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid == (add_last_valid || mul_last_valid));

    // R7
    add_drives_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !result_from_mul) |-> (add_last_valid && !mul_last_valid));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!result_valid && !add_stall));
endmodule

bind result_bus_arbiter rba_checker #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
) u_rba_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .add_last_valid  (add_last_valid),
    .add_last_tag    (add_last_tag),
    .add_last_data   (add_last_data),
    .mul_last_valid  (mul_last_valid),
    .result_valid    (result_valid),
    .result_from_mul (result_from_mul),
    .add_stall       (add_stall),
    .add_issue_ready (add_issue_ready)
);

// File: tb/tb_result_bus_arbiter.sv
`timescale 1ns/1ps
// Self-checking bench: a queue-based reference model, stepped once per clock.
module tb_result_bus_arbiter;
    localparam int ADD_LAT = 3;
    localparam int MUL_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        add_issue_valid = 1'b0;
    logic [3:0]  add_issue_tag = '0;
    logic [31:0] add_issue_data = '0;
    logic        add_issue_ready;
    logic        mul_issue_valid = 1'b0;
    logic [3:0]  mul_issue_tag = '0;
    logic [31:0] mul_issue_data = '0;
    logic        result_valid;
    logic [3:0]  result_tag;
    logic [31:0] result_data;
    logic        result_from_mul;
    logic        add_stall;

    always #2.5 clk = ~clk;

    result_bus_arbiter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .add_issue_valid (add_issue_valid),
        .add_issue_tag   (add_issue_tag),
        .add_issue_data  (add_issue_data),
        .add_issue_ready (add_issue_ready),
        .mul_issue_valid (mul_issue_valid),
        .mul_issue_tag   (mul_issue_tag),
        .mul_issue_data  (mul_issue_data),
        .result_valid    (result_valid),
        .result_tag      (result_tag),
        .result_data     (result_data),
        .result_from_mul (result_from_mul),
        .add_stall       (add_stall)
    );

    typedef struct {
        int          left;
        logic [3:0]  tag;
        logic [31:0] data;
    } op_t;

    op_t aq[$];
    op_t mq[$];
    int  checks = 0;
    int  errors = 0;
    int  issued[16];
    int  emitted[16];
    int  serial = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 16; i++) begin
            issued[i]  = 0;
            emitted[i] = 0;
        end
    endtask

    // One clock: compare outputs with the model, then drive inputs and step the model.
    task automatic step(input bit av, input bit mv);
        bit mul_due, add_due, stall;
        logic [31:0] d;
        @(negedge clk);
        mul_due = (mq.size() > 0) && (mq[0].left == 0);
        add_due = (aq.size() > 0) && (aq[0].left == 0);
        stall   = mul_due && add_due;
        chk(result_valid == (mul_due || add_due), "R7 result_valid", 64'(result_valid), 64'(mul_due || add_due));
        if (mul_due) begin
            chk(result_from_mul == 1'b1, "R3 source is multiplier", 64'(result_from_mul), 64'd1);
            chk(result_tag == mq[0].tag, "R2 multiply tag", 64'(result_tag), 64'(mq[0].tag));
            chk(result_data == mq[0].data, "R2 multiply data", 64'(result_data), 64'(mq[0].data));
        end else if (add_due) begin
            chk(result_from_mul == 1'b0, "R1 source is adder", 64'(result_from_mul), 64'd0);
            chk(result_tag == aq[0].tag, "R1 R4 R6 add tag", 64'(result_tag), 64'(aq[0].tag));
            chk(result_data == aq[0].data, "R1 R4 R6 add data", 64'(result_data), 64'(aq[0].data));
        end
        chk(add_stall == stall, "R5 add_stall", 64'(add_stall), 64'(stall));
        chk(add_issue_ready == !stall, "R5 R8 add_issue_ready", 64'(add_issue_ready), 64'(!stall));
        if (result_valid) emitted[result_tag]++;
        // Advance the model as the coming clock edge will.
        if (mul_due) void'(mq.pop_front());
        foreach (mq[i]) mq[i].left--;
        if (!stall) begin
            if (add_due) void'(aq.pop_front());
            foreach (aq[i]) aq[i].left--;
        end
        // Drive this cycle's issues.
        add_issue_valid = av;
        add_issue_tag   = serial[3:0];
        d = $urandom;
        add_issue_data  = d;
        if (av && !stall) begin
            aq.push_back('{ADD_LAT - 1, serial[3:0], d});
            issued[serial[3:0]]++;
            serial++;
        end
        mul_issue_valid = mv;
        mul_issue_tag   = serial[3:0];
        d = $urandom;
        mul_issue_data  = d;
        if (mv) begin
            mq.push_back('{MUL_LAT - 1, serial[3:0], d});
            issued[serial[3:0]]++;
            serial++;
        end
    endtask

    // Reset with the model emptied; checks the cleared outputs (R9).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        add_issue_valid = 1'b0;
        mul_issue_valid = 1'b0;
        aq.delete();
        mq.delete();
        clear_counts();
        repeat (2) begin
            @(negedge clk);
            chk(result_valid == 1'b0, "R9 result_valid after reset", 64'(result_valid), 64'd0);
            chk(add_stall == 1'b0, "R9 add_stall after reset", 64'(add_stall), 64'd0);
            chk(add_issue_ready == 1'b1, "R9 add_issue_ready after reset", 64'(add_issue_ready), 64'd1);
        end
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        clear_counts();
        do_reset();
        // Operations in flight, then reset in the middle (R9).
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        do_reset();
        // Lone add, latency R1.
        step(1'b1, 1'b0);
        repeat (5) step(1'b0, 1'b0);
        // Lone multiply, latency R2.
        step(1'b0, 1'b1);
        repeat (6) step(1'b0, 1'b0);
        // Multiply then add one cycle later: collision R3 R4.
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        repeat (7) step(1'b0, 1'b0);
        // Adds queued behind a held add: freeze R6.
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        repeat (10) step(1'b0, 1'b0);
        // Long multiply train with adds pushed all along: sustained hold R5 R8.
        repeat (12) step(1'b1, 1'b1);
        repeat (12) step(1'b0, 1'b0);
        // Random mix.
        repeat (4000) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0));
        repeat (30) step(1'b0, 1'b0);
        // Each accepted tag must have appeared exactly once (R7).
        for (int t = 0; t < 16; t++) begin
            chk(emitted[t] == issued[t], "R7 per-tag result count", 64'(emitted[t]), 64'(issued[t]));
        end
        finish_run();
    end
endmodule